// File: doc/BRIEF.md
# Data Storage Access Fault Checker

This block sits beside the data-side load/store path. On each cycle it may be handed one data memory access, together with the page attributes that translation has already produced. It decides whether that access must raise a data storage interrupt. The checks cover privilege-split read and write permission, a change of byte order when an access crosses into the next page, cache-line lock control from user mode, and storage synchronization rules for load-reserve and store-conditional. Touch and allocate hints are always exempt.

When a fault is taken, the block raises a single-cycle registered fault pulse and latches a syndrome: the winning cause, an instruction-lock flag, a data-lock flag and a store flag. Those values stay in place until the next fault. The block also tracks a reservation flag that load-reserve sets and store-conditional clears. The access port is a plain valid-qualified input. The block accepts an access on every cycle it is marked valid, so it never applies back-pressure and has no ready signal. Translation, vectoring and the cache itself are outside it.

Top module: `dacc_fault_check`

## Requirements
- R1: A read-type access (class 0 load, class 2 load-class cache op, class 10 load-reserve) faults with cause 2 when `priv_user`=1 and `perm_ur`=0, or when `priv_user`=0 and `perm_sr`=0.
- R2: A write-type access (class 1 store, class 3 store-class cache op, class 11 store-conditional) faults with cause 3 when `priv_user`=1 and `perm_uw`=0, or when `priv_user`=0 and `perm_sw`=0.
- R3: The hint classes 4, 5, 6 and 7 never fault, whatever the permissions, page attributes or crossing inputs.
- R4: A class 0, 1, 10 or 11 access with `cross_page`=1 and `pg_big_end` different from `pg2_big_end` faults with cause 4. The same access with equal endian bits does not fault for this reason.
- R5: The lock classes (8 instruction-cache lock/unlock, 9 data-cache lock/unlock) fault with cause 5 only when `priv_user`=1 and `ucl_en`=0. Page permissions are not checked for them.
- R6: On a cause-5 fault, `syn_ilk` is set for class 8 and `syn_dlk` is set for class 9. The two flags are never set together, and both are 0 for any other cause.
- R7: A class 10 or class 11 access to a page with `pg_wthru`=1 or `pg_cinh`=1 faults with cause 1.
- R8: A class 11 access that fails the R2 check faults with cause 3 whether or not the reservation is held.
- R9: A valid class 10 access that neither faults nor has `hi_pend` set makes `resv_held` 1 from the next cycle. Any valid class 11 access makes it 0 from the next cycle, whether or not it faults.
- R10: When several conditions apply to one access, the cause is chosen by priority: 1 (synchronization), then 2 or 3 (read or write), then 4 (byte order), then 5 (lock).
- R11: `fault` is a registered output that is high for exactly the cycle after a faulting access. The syndrome outputs change only on that same edge, and a non-faulting or invalid access leaves them unchanged.
- R12: An access presented with `hi_pend`=1 never raises `fault` and never writes the syndrome.
- R13: After reset, `fault`=0, `resv_held`=0 and the syndrome is all zero (cause 0 = none).
- R14: `syn_st` is latched as 1 for a fault on a write-type access (classes 1, 3, 11) and as 0 for any other faulting access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_class | input | 4 | Access class code (0..11, other codes are ignored) |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| ucl_en | input | 1 | User cache-lock enable |
| perm_ur | input | 1 | Page user-read permission |
| perm_sr | input | 1 | Page supervisor-read permission |
| perm_uw | input | 1 | Page user-write permission |
| perm_sw | input | 1 | Page supervisor-write permission |
| pg_big_end | input | 1 | Endian attribute of the first page |
| pg_wthru | input | 1 | Page is write-through required |
| pg_cinh | input | 1 | Page is caching inhibited |
| cross_page | input | 1 | Access crosses into the next page |
| pg2_big_end | input | 1 | Endian attribute of the second page |
| hi_pend | input | 1 | A higher-priority exception is already pending for this access |
| fault | output | 1 | Registered one-cycle data storage fault |
| syn_cause | output | 3 | Latched cause: 0 none, 1 sync, 2 read, 3 write, 4 byte order, 5 lock |
| syn_ilk | output | 1 | Latched instruction-cache lock flag |
| syn_dlk | output | 1 | Latched data-cache lock flag |
| syn_st | output | 1 | Latched store flag |
| resv_held | output | 1 | Reservation flag |

## Verification
Assertions check several rules on every cycle. The syndrome holds still unless a fault pulse accompanies it, and a fault always carries a real cause. The two lock flags are never both set. A pending higher exception, a hint or a permitted lock operation never yields a fault. Store-conditional always drops the reservation, and a clean load-reserve always sets it. Only the bench's scenarios can show which cause wins when several conditions overlap, and that the user/supervisor permission split picks the right bit. The same holds for byte-order faults depending on an actual endian change, and for reservation sequences across several accesses.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  localparam int CLS_W   = 4;
  localparam int CAUSE_W = 3;
  localparam int NCAUSE  = 5;

  typedef enum logic [CLS_W-1:0] {
    AC_LOAD      = 4'd0,
    AC_STORE     = 4'd1,
    AC_CM_LD     = 4'd2,
    AC_CM_ST     = 4'd3,
    AC_ITOUCH    = 4'd4,
    AC_DTOUCH    = 4'd5,
    AC_DTOUCH_ST = 4'd6,
    AC_DALLOC    = 4'd7,
    AC_ILOCK     = 4'd8,
    AC_DLOCK     = 4'd9,
    AC_LRSV      = 4'd10,
    AC_STCOND    = 4'd11
  } acc_cls_e;

  typedef enum logic [CAUSE_W-1:0] {
    FC_NONE  = 3'd0,
    FC_SYNC  = 3'd1,
    FC_READ  = 3'd2,
    FC_WRITE = 3'd3,
    FC_BORD  = 3'd4,
    FC_LOCK  = 3'd5
  } fcause_e;

  // Decoded properties of one access class
  typedef struct packed {
    logic rd;      // subject to read permission
    logic wr;      // subject to write permission
    logic hint;    // touch / allocate hint
    logic ilock;   // instruction-cache lock/unlock
    logic dlock;   // data-cache lock/unlock
    logic lrsv;    // load-reserve
    logic stcond;  // store-conditional
    logic xing;    // subject to page-crossing byte-order check
  } cls_attr_t;

  typedef struct packed {
    fcause_e cause;
    logic    ilk;
    logic    dlk;
    logic    st;
  } syn_t;

  localparam syn_t SYN_RST = '{cause: FC_NONE, ilk: 1'b0, dlk: 1'b0, st: 1'b0};

endpackage

// File: rtl/dacc_decode.sv
module dacc_decode
  import dacc_pkg::*;
(
  input  logic [CLS_W-1:0] cls_code,
  output cls_attr_t        attr
);

  always_comb begin
    attr = '0;
    case (cls_code)
      AC_LOAD:      begin attr.rd = 1'b1; attr.xing = 1'b1; end
      AC_STORE:     begin attr.wr = 1'b1; attr.xing = 1'b1; end
      AC_CM_LD:     attr.rd = 1'b1;
      AC_CM_ST:     attr.wr = 1'b1;
      AC_ITOUCH,
      AC_DTOUCH,
      AC_DTOUCH_ST,
      AC_DALLOC:    attr.hint = 1'b1;
      AC_ILOCK:     attr.ilock = 1'b1;
      AC_DLOCK:     attr.dlock = 1'b1;
      AC_LRSV:      begin attr.rd = 1'b1; attr.lrsv = 1'b1; attr.xing = 1'b1; end
      AC_STCOND:    begin attr.wr = 1'b1; attr.stcond = 1'b1; attr.xing = 1'b1; end
      default:      attr = '0;
    endcase
  end

endmodule

// File: rtl/dacc_fault_eval.sv
module dacc_fault_eval
  import dacc_pkg::*;
(
  input  cls_attr_t attr,
  input  logic      priv_user,
  input  logic      ucl_en,
  input  logic      perm_ur,
  input  logic      perm_sr,
  input  logic      perm_uw,
  input  logic      perm_sw,
  input  logic      pg_big_end,
  input  logic      pg_wthru,
  input  logic      pg_cinh,
  input  logic      cross_page,
  input  logic      pg2_big_end,
  output logic      hit,
  output syn_t      syn
);

  // Index 0 is the highest priority
  localparam fcause_e PRIO [NCAUSE] = '{FC_SYNC, FC_READ, FC_WRITE, FC_BORD, FC_LOCK};

  logic rd_ok, wr_ok;
  logic [NCAUSE-1:0] req;

  assign rd_ok = priv_user ? perm_ur : perm_sr;
  assign wr_ok = priv_user ? perm_uw : perm_sw;

  always_comb begin
    req    = '0;
    req[0] = (attr.lrsv | attr.stcond) & (pg_wthru | pg_cinh);
    req[1] = attr.rd & ~rd_ok;
    req[2] = attr.wr & ~wr_ok;
    req[3] = attr.xing & cross_page & (pg_big_end ^ pg2_big_end);
    req[4] = (attr.ilock | attr.dlock) & priv_user & ~ucl_en;
    if (attr.hint) req = '0;
  end

  fcause_e win;
  always_comb begin
    win = FC_NONE;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (req[i]) win = PRIO[i];
    end
  end

  assign hit       = |req;
  assign syn.cause = win;
  assign syn.ilk   = attr.ilock & (win == FC_LOCK);
  assign syn.dlk   = attr.dlock & (win == FC_LOCK);
  assign syn.st    = attr.wr;

endmodule

// File: rtl/dacc_state.sv
module dacc_state
  import dacc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  syn_t syn_in,
  input  logic acc_valid,
  input  logic is_lrsv,
  input  logic is_stcond,
  input  logic hi_pend,
  output logic fault_q,
  output syn_t syn_q,
  output logic resv_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      syn_q   <= SYN_RST;
    end else begin
      fault_q <= take;
      if (take) syn_q <= syn_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_q <= 1'b0;
    end else if (acc_valid && is_stcond) begin
      resv_q <= 1'b0;
    end else if (acc_valid && is_lrsv && !take && !hi_pend) begin
      resv_q <= 1'b1;
    end
  end

  // R11: syndrome moves only on the edge that raises the fault pulse
  a_r11_syn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q |-> $stable(syn_q));

  // R6: lock flags are exclusive
  a_r6_lock_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({syn_q.ilk, syn_q.dlk}));

  // R9: store-conditional drops the reservation
  a_r9_stcond_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && is_stcond |=> !resv_q);

  // R9: clean load-reserve sets it
  a_r9_lrsv_sets: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && is_lrsv && !take && !hi_pend |=> resv_q);

endmodule

// File: rtl/dacc_fault_check.sv
module dacc_fault_check
  import dacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [CLS_W-1:0]  acc_class,
  input  logic              priv_user,
  input  logic              ucl_en,
  input  logic              perm_ur,
  input  logic              perm_sr,
  input  logic              perm_uw,
  input  logic              perm_sw,
  input  logic              pg_big_end,
  input  logic              pg_wthru,
  input  logic              pg_cinh,
  input  logic              cross_page,
  input  logic              pg2_big_end,
  input  logic              hi_pend,
  output logic              fault,
  output logic [CAUSE_W-1:0] syn_cause,
  output logic              syn_ilk,
  output logic              syn_dlk,
  output logic              syn_st,
  output logic              resv_held
);

  cls_attr_t attr;
  syn_t      syn_c, syn_r;
  logic      hit, take;

  dacc_decode u_dec (
    .cls_code (acc_class),
    .attr     (attr)
  );

  dacc_fault_eval u_eval (
    .attr        (attr),
    .priv_user   (priv_user),
    .ucl_en      (ucl_en),
    .perm_ur     (perm_ur),
    .perm_sr     (perm_sr),
    .perm_uw     (perm_uw),
    .perm_sw     (perm_sw),
    .pg_big_end  (pg_big_end),
    .pg_wthru    (pg_wthru),
    .pg_cinh     (pg_cinh),
    .cross_page  (cross_page),
    .pg2_big_end (pg2_big_end),
    .hit         (hit),
    .syn         (syn_c)
  );

  assign take = acc_valid & hit & ~hi_pend;

  dacc_state u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .syn_in    (syn_c),
    .acc_valid (acc_valid),
    .is_lrsv   (attr.lrsv),
    .is_stcond (attr.stcond),
    .hi_pend   (hi_pend),
    .fault_q   (fault),
    .syn_q     (syn_r),
    .resv_q    (resv_held)
  );

  assign syn_cause = syn_r.cause;
  assign syn_ilk   = syn_r.ilk;
  assign syn_dlk   = syn_r.dlk;
  assign syn_st    = syn_r.st;

  // R12: pending higher exception suppresses the fault
  a_r12_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && hi_pend |=> !fault);

  // R3: hints never fault
  a_r3_hint_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_class inside {4'd4, 4'd5, 4'd6, 4'd7}) |=> !fault);

  // R5: lock operations in supervisor mode or with user lock enabled pass
  a_r5_lock_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_class inside {4'd8, 4'd9}) && (!priv_user || ucl_en) |=> !fault);

  // R11: a fault pulse always carries a real cause
  a_r11_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (syn_cause != 3'd0));

endmodule

// File: tb/tb_dacc_fault_check.sv
module tb_dacc_fault_check;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] cls;
    logic usr, ucle, ur, sr, uw, sw, be, wt, ci, cr, be2, pend;
    logic       ef;
    logic [2:0] ec;
    logic       eilk, edlk, est;
    logic [3:0] rq;
  } vec_t;

  // fields: cls usr ucle ur sr uw sw be wt ci cr be2 pend | ef ec ilk dlk st | req
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 1,0,0,1,1,1,0,0,0,0,0,0, 1,3'd2,0,0,0, 4'd1},  // R1 user read denied
    '{4'd0, 1,0,1,0,1,1,0,0,0,0,0,0, 0,3'd0,0,0,0, 4'd1},  // R1 user read ok
    '{4'd0, 0,0,1,0,1,1,0,0,0,0,0,0, 1,3'd2,0,0,0, 4'd1},  // R1 supervisor read denied
    '{4'd2, 1,0,0,1,1,1,0,0,0,0,0,0, 1,3'd2,0,0,0, 4'd1},  // R1 cache load-class
    '{4'd1, 1,0,1,1,0,1,0,0,0,0,0,0, 1,3'd3,0,0,1, 4'd2},  // R2 user write denied, R14
    '{4'd1, 0,0,1,1,1,0,0,0,0,0,0,0, 1,3'd3,0,0,1, 4'd2},  // R2 supervisor write denied
    '{4'd3, 0,0,1,1,0,1,0,0,0,0,0,0, 0,3'd0,0,0,0, 4'd2},  // R2 supervisor store-class ok
    '{4'd5, 1,0,0,0,0,0,0,1,1,1,1,0, 0,3'd0,0,0,0, 4'd3},  // R3 data touch
    '{4'd7, 1,0,0,0,0,0,0,1,1,1,1,0, 0,3'd0,0,0,0, 4'd3},  // R3 allocate
    '{4'd4, 0,0,0,0,0,0,1,1,1,1,0,0, 0,3'd0,0,0,0, 4'd3},  // R3 instruction touch
    '{4'd6, 1,0,0,0,0,0,0,0,0,1,1,0, 0,3'd0,0,0,0, 4'd3},  // R3 touch for store
    '{4'd0, 0,0,1,1,1,1,0,0,0,1,1,0, 1,3'd4,0,0,0, 4'd4},  // R4 endian change
    '{4'd1, 0,0,1,1,1,1,1,0,0,1,1,0, 0,3'd0,0,0,0, 4'd4},  // R4 same endian
    '{4'd8, 1,0,1,1,1,1,0,0,0,0,0,0, 1,3'd5,1,0,0, 4'd6},  // R6 instruction lock
    '{4'd9, 1,0,1,1,1,1,0,0,0,0,0,0, 1,3'd5,0,1,0, 4'd6},  // R6 data lock
    '{4'd9, 1,1,1,1,1,1,0,0,0,0,0,0, 0,3'd0,0,0,0, 4'd5},  // R5 user lock enabled
    '{4'd8, 0,0,1,1,1,1,0,0,0,0,0,0, 0,3'd0,0,0,0, 4'd5},  // R5 supervisor lock
    '{4'd8, 1,0,0,0,0,0,0,0,0,0,0,0, 1,3'd5,1,0,0, 4'd5},  // R5 perms not checked
    '{4'd10,0,0,1,1,1,1,0,0,1,0,0,0, 1,3'd1,0,0,0, 4'd7},  // R7 load-reserve inhibited
    '{4'd11,0,0,1,1,1,1,0,1,0,0,0,0, 1,3'd1,0,0,1, 4'd7},  // R7 store-cond write-through
    '{4'd10,0,0,0,0,1,1,0,1,0,1,1,0, 1,3'd1,0,0,0, 4'd10}, // R10 sync beats read and byte order
    '{4'd0, 1,0,0,1,1,1,0,0,0,1,1,0, 1,3'd2,0,0,0, 4'd10}, // R10 read beats byte order
    '{4'd11,1,0,1,1,0,1,0,0,0,0,0,0, 1,3'd3,0,0,1, 4'd8},  // R8 store-cond write denied
    '{4'd0, 1,0,0,0,0,0,0,1,1,1,1,1, 0,3'd0,0,0,0, 4'd12}  // R12 pending suppresses
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [3:0] acc_class = '0;
  logic priv_user = 0, ucl_en = 0, perm_ur = 0, perm_sr = 0, perm_uw = 0, perm_sw = 0;
  logic pg_big_end = 0, pg_wthru = 0, pg_cinh = 0, cross_page = 0, pg2_big_end = 0, hi_pend = 0;
  logic fault, syn_ilk, syn_dlk, syn_st, resv_held;
  logic [2:0] syn_cause;

  int checks = 0;
  int fails  = 0;
  logic [5:0] exp_syn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacc_fault_check dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_class(acc_class),
    .priv_user(priv_user), .ucl_en(ucl_en), .perm_ur(perm_ur), .perm_sr(perm_sr),
    .perm_uw(perm_uw), .perm_sw(perm_sw), .pg_big_end(pg_big_end), .pg_wthru(pg_wthru),
    .pg_cinh(pg_cinh), .cross_page(cross_page), .pg2_big_end(pg2_big_end), .hi_pend(hi_pend),
    .fault(fault), .syn_cause(syn_cause), .syn_ilk(syn_ilk), .syn_dlk(syn_dlk),
    .syn_st(syn_st), .resv_held(resv_held)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic vec_t base(input logic [3:0] c, input logic u);
    vec_t v = '0;
    v.cls = c; v.usr = u; v.ur = 1; v.sr = 1; v.uw = 1; v.sw = 1;
    return v;
  endfunction

  task automatic drive(input vec_t v, input logic vld);
    acc_valid = vld; acc_class = v.cls; priv_user = v.usr; ucl_en = v.ucle;
    perm_ur = v.ur; perm_sr = v.sr; perm_uw = v.uw; perm_sw = v.sw;
    pg_big_end = v.be; pg_wthru = v.wt; pg_cinh = v.ci; cross_page = v.cr;
    pg2_big_end = v.be2; hi_pend = v.pend;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    vec_t v;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    // R13 reset state (still in reset)
    chk(fault == 0, "R13 fault", fault, 0);
    chk(resv_held == 0, "R13 resv", resv_held, 0);
    chk({syn_cause, syn_ilk, syn_dlk, syn_st} == 6'd0, "R13 syndrome",
        {syn_cause, syn_ilk, syn_dlk, syn_st}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: drive at negedge, check one edge later
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      @(negedge clk);
      chk(fault == TBL[i].ef, $sformatf("R%0d fault vec %0d", TBL[i].rq, i), fault, TBL[i].ef);
      if (TBL[i].ef) exp_syn = {TBL[i].ec, TBL[i].eilk, TBL[i].edlk, TBL[i].est};
      // R11 syndrome written only on fault, R14 store flag, R6 lock flags
      chk({syn_cause, syn_ilk, syn_dlk, syn_st} == exp_syn,
          $sformatf("R%0d/R11 syndrome vec %0d", TBL[i].rq, i),
          {syn_cause, syn_ilk, syn_dlk, syn_st}, exp_syn);
    end

    // R11 one-cycle pulse: faulting access then idle
    v = base(4'd0, 1'b1); v.ur = 0;
    drive(v, 1'b1); @(negedge clk);
    chk(fault == 1, "R11 pulse high", fault, 1);
    drive(v, 1'b0); @(negedge clk);
    chk(fault == 0, "R11 pulse one cycle", fault, 0);
    // R11 invalid access with faulting fields leaves syndrome alone
    v = base(4'd9, 1'b1);
    drive(v, 1'b0); @(negedge clk);
    chk(fault == 0, "R11 invalid no fault", fault, 0);
    chk(syn_cause == 3'd2, "R11 invalid keeps cause", syn_cause, 2);

    // R9 reservation sequences
    drive(base(4'd10, 1'b0), 1'b1); @(negedge clk);
    chk(resv_held == 1, "R9 load-reserve sets", resv_held, 1);
    drive(base(4'd5, 1'b0), 1'b1); @(negedge clk);
    chk(resv_held == 1, "R9 hint keeps", resv_held, 1);
    drive(base(4'd11, 1'b0), 1'b1); @(negedge clk);
    chk(resv_held == 0, "R9 store-cond clears", resv_held, 0);
    chk(fault == 0, "R9 store-cond clean", fault, 0);
    drive(base(4'd10, 1'b0), 1'b1); @(negedge clk);
    chk(resv_held == 1, "R9 set again", resv_held, 1);
    v = base(4'd11, 1'b1); v.uw = 0;
    drive(v, 1'b1); @(negedge clk);
    chk(resv_held == 0, "R9 faulting store-cond clears", resv_held, 0);
    chk(fault == 1 && syn_cause == 3'd3, "R8 fault with reservation held", syn_cause, 3);
    drive(v, 1'b1); @(negedge clk);
    chk(fault == 1 && syn_cause == 3'd3, "R8 fault without reservation", syn_cause, 3);
    v = base(4'd10, 1'b0); v.ci = 1;
    drive(v, 1'b1); @(negedge clk);
    chk(resv_held == 0, "R9 faulting load-reserve no set", resv_held, 0);
    v = base(4'd10, 1'b0); v.pend = 1;
    drive(v, 1'b1); @(negedge clk);
    chk(resv_held == 0, "R9 pending load-reserve no set", resv_held, 0);
    chk(fault == 0, "R12 pending no fault", fault, 0);
    chk(syn_cause == 3'd1, "R12 syndrome kept", syn_cause, 1);

    drive('0, 1'b0); @(negedge clk);
    summary();
  end

endmodule